// File: doc/BRIEF.md
# PHY Management Command Engine

This block carries out one management register transaction with an external PHY for each command that software issues. Software writes a single 32-bit command word. The word holds the PHY address, the register number, a read/write select, the write data and a start flag.

When the start flag is accepted, the engine sends a complete 64-bit management frame on the serial clock and data pins. While the frame runs, the start flag reads back as set. It clears itself once the last bit has been sent. After a read, the data returned by the PHY appears in the upper half of the same command word. A read that comes back as all ones means that nothing answered, and the engine stores zero instead.

A build-time option covers a PHY built into the same chip. With this option set, only address 0 exists. A command aimed at any other address finishes at once, without a frame, and a read of such an address returns zero. The serial clock is the system clock divided by a parameter.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads 0x00000000, the serial clock is low and the data pin driver is disabled with its output at 0.
- R2: The command word fields are: data in bits 31:16, PHY address in bits 15:11, register number in bits 10:6, the read select in bit 3 (1 = read, 0 = write) and the start flag in bit 4. Bits 5 and 2:0 read as 0. A write with bit 4 clear stores the fields and starts nothing.
- R3: A write with bit 4 set starts a frame. Bit 4 reads as 1 from the next cycle for 128*HALF_PERIOD cycles, and then reads as 0.
- R4: During a frame, each of the 64 bit periods holds the serial clock low for HALF_PERIOD cycles and then high for HALF_PERIOD cycles. When idle, the serial clock is low.
- R5: The data pin changes only where the serial clock falls. It carries, most significant bit first: 32 ones, then 01, then the opcode (10 for read, 01 for write), then the 5 address bits, then the 5 register bits, then the turnaround (10 on writes), then 16 data bits.
- R6: On a read, the data pin driver is disabled from the first turnaround bit (bit 46) to the end of the frame. On a write, it is enabled for all 64 bits.
- R7: On a read, the PHY data is sampled on the serial clock rising edge in bits 48 to 63. It appears in bits 31:16 of the command word in the same cycle that bit 4 clears.
- R8: A read that returns 0xFFFF leaves 0x0000 in bits 31:16.
- R9: A write to the command word while bit 4 is set has no effect.
- R10: With INTEGRATED_PHY set, a command with bit 4 set and a nonzero address issues no frame and clears bit 4 by the next cycle. If it is a read, bits 31:16 become 0.
- R11: With INTEGRATED_PHY set, a command to address 0 runs a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Write strobe for the command word |
| cmdWrData | input | 32 | Command word value to write |
| cmdRdData | output | 32 | Current command word, including status and read data |
| mdc | output | 1 | Serial management clock |
| mdioOut | output | 1 | Data value to drive onto the management data pin |
| mdioOe | output | 1 | Driver enable for the management data pin |
| mdioIn | input | 1 | Sampled management data pin |

## Verification
The assertions assume that nothing other than a command write can start a frame. They also assume the PHY keeps the data pin steady around each rising serial clock edge in the data bits. The stimulus changes the PHY response and all command inputs only on the falling system clock edge. It holds each response bit for a whole serial bit period, and it inserts a command write in the middle of a running frame to exercise the ignore path. With the built-in PHY option, commands go to both a nonzero address and address 0, and the unanswered read is left floating high.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int FRAME_BITS     = 64;
  localparam int BIT_IDX_W      = $clog2(FRAME_BITS);
  localparam int DATA_W         = 16;
  localparam int ADDR_W         = 5;
  localparam int ACC_BIT        = 4;
  localparam int OP_BIT         = 3;
  localparam int PHY_LSB        = 11;
  localparam int REG_LSB        = 6;
  localparam int DATA_LSB       = 16;
  localparam int RD_RELEASE_BIT = 46;
  localparam int DATA_FIRST_BIT = 48;

  typedef struct packed {
    logic launch;
    logic riseEdge;
    logic fallEdge;
    logic finish;
  } engStrobe_t;
endpackage

// File: rtl/mdio_eng_ctrl.sv
module mdio_eng_ctrl
  import mdio_eng_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  output engStrobe_t           strb,
  output logic [BIT_IDX_W-1:0] bitIdx,
  output logic                 busy,
  output logic                 mdc
);
  localparam int CNT_W = $clog2(HALF_PERIOD + 1);

  logic [CNT_W-1:0] divCnt;
  logic             tick;

  assign tick = busy && (divCnt == CNT_W'(HALF_PERIOD - 1));

  always_comb begin
    strb.launch   = startReq && !busy;
    strb.riseEdge = tick && !mdc;
    strb.fallEdge = tick && mdc;
    strb.finish   = tick && mdc && (bitIdx == BIT_IDX_W'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (strb.launch) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) mdc <= ~mdc;
      if (strb.finish) begin
        busy   <= 1'b0;
        bitIdx <= '0;
      end else if (strb.fallEdge) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
endmodule

// File: rtl/mdio_eng_dp.sv
module mdio_eng_dp
  import mdio_eng_pkg::*;
#(
  parameter bit INTEGRATED_PHY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdWrEn,
  input  logic [31:0]          cmdWrData,
  input  engStrobe_t           strb,
  input  logic [BIT_IDX_W-1:0] bitIdx,
  input  logic                 mdioIn,
  output logic                 startReq,
  output logic                 accessBit,
  output logic [31:0]          cmdRdData,
  output logic                 mdioOut,
  output logic                 mdioOe
);
  logic [DATA_W-1:0]     dataReg;
  logic [ADDR_W-1:0]     phyReg;
  logic [ADDR_W-1:0]     regReg;
  logic                  opRead;
  logic [FRAME_BITS-1:0] frameSh;
  logic [DATA_W-1:0]     rdSh;
  logic                  oeReg;

  logic                  wrAccepted;
  logic                  addrBlocked;
  logic                  wrIsRead;
  logic [ADDR_W-1:0]     wrPhy;
  logic [ADDR_W-1:0]     wrReg;
  logic [DATA_W-1:0]     wrDat;
  logic [FRAME_BITS-1:0] newFrame;
  logic                  unusedWrBits;

  assign wrIsRead     = cmdWrData[OP_BIT];
  assign wrPhy        = cmdWrData[PHY_LSB +: ADDR_W];
  assign wrReg        = cmdWrData[REG_LSB +: ADDR_W];
  assign wrDat        = cmdWrData[DATA_LSB +: DATA_W];
  assign unusedWrBits = ^{cmdWrData[5], cmdWrData[2:0]};

  assign wrAccepted  = cmdWrEn && !accessBit;
  assign addrBlocked = INTEGRATED_PHY && (wrPhy != '0);
  assign startReq    = wrAccepted && cmdWrData[ACC_BIT] && !addrBlocked;

  assign newFrame = {32'hFFFF_FFFF, 2'b01,
                     wrIsRead ? 2'b10 : 2'b01,
                     wrPhy, wrReg,
                     wrIsRead ? 2'b11 : 2'b10,
                     wrIsRead ? {DATA_W{1'b0}} : wrDat};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= '0;
      phyReg    <= '0;
      regReg    <= '0;
      opRead    <= 1'b0;
      accessBit <= 1'b0;
      frameSh   <= '0;
      rdSh      <= '0;
      oeReg     <= 1'b0;
    end else begin
      if (wrAccepted) begin
        phyReg    <= wrPhy;
        regReg    <= wrReg;
        opRead    <= wrIsRead;
        dataReg   <= (cmdWrData[ACC_BIT] && addrBlocked && wrIsRead) ? '0 : wrDat;
        accessBit <= startReq;
      end
      if (strb.launch) begin
        frameSh <= newFrame;
        oeReg   <= 1'b1;
        rdSh    <= '0;
      end else begin
        if (strb.riseEdge && opRead && bitIdx >= BIT_IDX_W'(DATA_FIRST_BIT))
          rdSh <= {rdSh[DATA_W-2:0], mdioIn};
        if (strb.finish) begin
          accessBit <= 1'b0;
          oeReg     <= 1'b0;
          if (opRead) dataReg <= (rdSh == '1) ? '0 : rdSh;
        end else if (strb.fallEdge) begin
          frameSh <= frameSh << 1;
          if (opRead && bitIdx == BIT_IDX_W'(RD_RELEASE_BIT - 1)) oeReg <= 1'b0;
        end
      end
    end
  end

  assign mdioOe    = oeReg;
  assign mdioOut   = oeReg & frameSh[FRAME_BITS-1];
  assign cmdRdData = {dataReg, phyReg, regReg, 1'b0, accessBit, opRead, 3'b000};

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessBit && opRead && bitIdx >= BIT_IDX_W'(RD_RELEASE_BIT) |-> !mdioOe);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessBit && cmdWrEn |=> $stable(phyReg) && $stable(regReg) && $stable(opRead));

  // R8
  no_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accessBit) && opRead |-> dataReg != 16'hFFFF);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_eng_pkg::*;
#(
  parameter int HALF_PERIOD    = 4,
  parameter bit INTEGRATED_PHY = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  output logic [31:0] cmdRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  engStrobe_t           strb;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic                 busy;
  logic                 startReq;
  logic                 accessBit;

  mdio_eng_ctrl #(.HALF_PERIOD(HALF_PERIOD)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strb(strb), .bitIdx(bitIdx), .busy(busy), .mdc(mdc)
  );

  mdio_eng_dp #(.INTEGRATED_PHY(INTEGRATED_PHY)) uDp (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .strb(strb), .bitIdx(bitIdx), .mdioIn(mdioIn),
    .startReq(startReq), .accessBit(accessBit), .cmdRdData(cmdRdData),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  // R3
  acc_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessBit == busy);

  // R10
  phy_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |-> !(INTEGRATED_PHY && cmdWrData[15:11] != 5'd0));
endmodule

// File: tb/sim_mdio_cmd_engine.sv
`timescale 1ns/1ps
module sim_mdio_cmd_engine;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  logic        u1WrEn = 1'b0;
  logic [31:0] u1WrData = '0;
  logic [31:0] u1Rd;
  logic        u1Mdc, u1Out, u1Oe;
  logic        u1In = 1'b1;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mdio_cmd_engine #(.HALF_PERIOD(H), .INTEGRATED_PHY(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .cmdWrEn(wrEn), .cmdWrData(wrData), .cmdRdData(rdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  mdio_cmd_engine #(.HALF_PERIOD(H), .INTEGRATED_PHY(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .cmdWrEn(u1WrEn), .cmdWrData(u1WrData), .cmdRdData(u1Rd),
    .mdc(u1Mdc), .mdioOut(u1Out), .mdioOe(u1Oe), .mdioIn(u1In)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mkWord(logic [15:0] d, logic [4:0] p, logic [4:0] r,
                                         logic acc, logic rd);
    return {d, p, r, 1'b0, acc, rd, 3'b000};
  endfunction

  // Reference model: expected pins and word per cycle after the start edge.
  task automatic runCmd(input logic isRead, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input logic [15:0] resp, input bit poke);
    logic [63:0] bits;
    logic [31:0] word;
    word = mkWord(wd, phy, rg, 1'b1, isRead);
    bits = {32'hFFFF_FFFF, 2'b01, isRead ? 2'b10 : 2'b01, phy, rg,
            isRead ? 2'b11 : 2'b10, isRead ? 16'h0000 : wd};
    @(negedge clk);
    wrEn = 1'b1; wrData = word;
    @(negedge clk);
    wrEn = 1'b0;
    for (int k = 0; k <= 128 * H; k++) begin
      int b;
      logic expMdc, expOe, expOut;
      logic [31:0] expWord;
      string endTag;
      b = k / (2 * H);
      if (k < 128 * H) begin
        expMdc  = ((k / H) % 2) == 1;
        expOe   = !(isRead && b >= 46);
        expOut  = expOe & bits[63 - b];
        expWord = word;
        mdioIn  = (b >= 48) ? resp[63 - b] : 1'b1;
        chk("R4", "mdc", {31'd0, mdc}, {31'd0, expMdc});
        chk("R6", "mdioOe", {31'd0, mdioOe}, {31'd0, expOe});
        chk("R5", "mdioOut", {31'd0, mdioOut}, {31'd0, expOut});
        chk(k == 11 ? "R9" : "R3", "word busy", rdData, expWord);
      end else begin
        mdioIn  = 1'b1;
        expWord = mkWord(isRead ? ((resp == 16'hFFFF) ? 16'h0000 : resp) : wd,
                         phy, rg, 1'b0, isRead);
        endTag  = !isRead ? "R3" : (resp == 16'hFFFF) ? "R8" : "R7";
        chk(endTag, "word done", rdData, expWord);
        chk("R4", "mdc idle", {31'd0, mdc}, 32'd0);
        chk("R6", "oe idle", {31'd0, mdioOe}, 32'd0);
      end
      if (poke && k == 10) begin
        wrEn = 1'b1;
        wrData = mkWord(~wd, ~phy, ~rg, 1'b1, ~isRead);
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state on both instances
    chk("R1", "word", rdData, 32'h0);
    chk("R1", "mdc", {31'd0, mdc}, 32'd0);
    chk("R1", "oe", {31'd0, mdioOe}, 32'd0);
    chk("R1", "out", {31'd0, mdioOut}, 32'd0);
    chk("R1", "u1 word", u1Rd, 32'h0);

    // R2: field store without start
    wrEn = 1'b1;
    wrData = mkWord(16'hA5C3, 5'd9, 5'd17, 1'b0, 1'b1) | 32'h0000_0027;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R2", "stored fields", rdData, mkWord(16'hA5C3, 5'd9, 5'd17, 1'b0, 1'b1));
    repeat (4) begin
      @(negedge clk);
      chk("R2", "no frame mdc", {31'd0, mdc}, 32'd0);
      chk("R2", "no frame oe", {31'd0, mdioOe}, 32'd0);
    end

    // R3 R5 R9: write frame with a write during busy
    runCmd(1'b0, 5'd1, 5'd4, 16'h5A0F, 16'h0000, 1'b1);
    // R7: read frame
    runCmd(1'b1, 5'd19, 5'd2, 16'h1111, 16'hBEEF, 1'b0);
    // R8: no device answers
    runCmd(1'b1, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 1'b0);
    // R7: sparse pattern, poke during read
    runCmd(1'b1, 5'd0, 5'd0, 16'h0000, 16'h8001, 1'b1);
    runCmd(1'b0, 5'd21, 5'd10, 16'hFFFF, 16'h0000, 1'b0);

    // R10: built-in PHY option, nonzero address
    @(negedge clk);
    u1WrEn = 1'b1; u1WrData = mkWord(16'h7777, 5'd3, 5'd1, 1'b1, 1'b1);
    @(negedge clk);
    u1WrEn = 1'b0;
    chk("R10", "blocked read", u1Rd, mkWord(16'h0000, 5'd3, 5'd1, 1'b0, 1'b1));
    repeat (20) begin
      @(negedge clk);
      chk("R10", "no mdc", {31'd0, u1Mdc}, 32'd0);
      chk("R10", "no oe", {31'd0, u1Oe}, 32'd0);
    end
    u1WrEn = 1'b1; u1WrData = mkWord(16'h1234, 5'd7, 5'd9, 1'b1, 1'b0);
    @(negedge clk);
    u1WrEn = 1'b0;
    chk("R10", "blocked write", u1Rd, mkWord(16'h1234, 5'd7, 5'd9, 1'b0, 1'b0));

    // R11: address 0 runs a frame; floating input reads as no device
    u1WrEn = 1'b1; u1WrData = mkWord(16'h4444, 5'd0, 5'd3, 1'b1, 1'b1);
    @(negedge clk);
    u1WrEn = 1'b0;
    chk("R11", "started", u1Rd, mkWord(16'h4444, 5'd0, 5'd3, 1'b1, 1'b1));
    chk("R11", "driving", {31'd0, u1Oe}, 32'd1);
    repeat (H) @(negedge clk);
    chk("R11", "mdc high", {31'd0, u1Mdc}, 32'd1);
    repeat (128 * H - H) @(negedge clk);
    chk("R11", "done word", u1Rd, mkWord(16'h0000, 5'd0, 5'd3, 1'b0, 1'b1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule